// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block gathers per-channel event pulses from a bank of DMA channels and turns them into sticky status flags, which software can read and clear, plus one interrupt line per channel. Each channel reports three kinds of event: transfer done, halfway reached, and transfer fault. Each pulse sets its own flag. A fourth per-channel bit, the summary flag, reads as the OR of the other three.

Software works through a small register port with a write strobe, a 2-bit address, write data and combinational read data. The status word can only be read. A separate clear word is write-one-to-clear: a 1 clears the matching flag and a 0 leaves it alone. Writing 1 to a channel's summary position clears all three of its flags together. An enable word holds one bit per channel for each event kind. These bits decide only which flags drive the channel's interrupt line. They never change the flags themselves.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every flag, every enable bit and every interrupt output is zero.
- R2: An event pulse in a cycle sets its flag at the next rising edge. The status word sits at address 0. Channel n uses bits 4n (summary), 4n+1 (done), 4n+2 (halfway) and 4n+3 (fault).
- R3: The summary bit 4n reads 1 exactly when at least one of the channel's done, halfway or fault flags is set.
- R4: A write to address 1 with a 1 at bit 4n+1, 4n+2 or 4n+3 clears that single flag at the edge. Bits written as 0 leave their flags unchanged.
- R5: A write to address 1 with a 1 at bit 4n clears all three of channel n's flags at the edge.
- R6: When an event and a clear reach the same flag in the same cycle, the flag ends up set.
- R7: Writes to address 0 have no effect on any flag.
- R8: Address 1 (clear word) and address 3 always read as zero.
- R9: Address 2 is the enable word. Bits 4n+1, 4n+2 and 4n+3 enable done, halfway and fault for channel n. They are writable and read back. Bit 4n always reads zero.
- R10: irq_o[n] is high while any of channel n's flags is set with its enable bit set. Enable bits never alter the status flags.
- R11: With no event and no clear, the flags hold their values, and each channel's flags move independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tc_evt_i | input | NUM_CH | Transfer-done pulse per channel |
| ht_evt_i | input | NUM_CH | Halfway pulse per channel |
| te_evt_i | input | NUM_CH | Transfer-fault pulse per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 status, 1 clear, 2 enable) |
| reg_wdata_i | input | 4*NUM_CH | Register write data |
| reg_rdata_o | output | 4*NUM_CH | Combinational register read data |
| irq_o | output | NUM_CH | Interrupt line per channel |

## Verification
An event pulse, a clear write and an enable write all take effect at the first rising edge after they are presented. The read port and the interrupt lines are combinational, so every result can be seen one edge after its stimulus. The bench drives each stimulus at a falling edge and waits for one rising edge. It then returns the inputs to idle and reads the status, enable or clear address before the next edge, so each check observes the result of exactly one stimulus. The set-versus-clear and summary-clear cases are applied within a single cycle to exercise the same-edge priority.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int FLAGS_PER_CH = 4;
  localparam int EVT_PER_CH   = 3;
  localparam int BIT_GLB      = 0;
  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_CLR  = 2'd1,
    ADDR_EN   = 2'd2,
    ADDR_RSV  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [EVT_PER_CH-1:0]   evt_i,   // done, halfway, fault
  input  logic [FLAGS_PER_CH-1:0] clr_i,   // summary, done, halfway, fault
  input  logic [EVT_PER_CH-1:0]   en_i,
  output logic [FLAGS_PER_CH-1:0] flags_o,
  output logic                    irq_o
);
  logic [EVT_PER_CH-1:0] flag_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else begin
      for (int k = 0; k < EVT_PER_CH; k++)
        flag_q[k] <= evt_i[k] | (flag_q[k] & ~(clr_i[k+1] | clr_i[BIT_GLB]));
    end
  end

  assign flags_o = {flag_q, |flag_q};
  assign irq_o   = |(flag_q & en_i);

  for (genvar k = 0; k < EVT_PER_CH; k++) begin : g_chk
    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> flags_o[k+1]);
    assert_single_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k+1] && !evt_i[k]) |=> !flags_o[k+1]);
  end

  assert_glb_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[BIT_GLB] && evt_i == '0) |=> flags_o == '0);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0 && clr_i == '0) |=> $stable(flags_o));
  assert_glb_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[BIT_GLB]) |-> $past(evt_i) != '0);
  assert_irq_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags_o[BIT_GLB]);
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [1:0]                   addr_i,
  input  logic [FLAGS_PER_CH*NUM_CH-1:0] wdata_i,
  input  logic [FLAGS_PER_CH*NUM_CH-1:0] flags_i,
  output logic [FLAGS_PER_CH*NUM_CH-1:0] clr_o,
  output logic [EVT_PER_CH*NUM_CH-1:0]   en_o,
  output logic [FLAGS_PER_CH*NUM_CH-1:0] rdata_o
);
  localparam int SW = FLAGS_PER_CH * NUM_CH;
  localparam int EW = EVT_PER_CH * NUM_CH;

  logic [EW-1:0] en_q;
  logic [SW-1:0] en_rd;
  logic          wr_clr, wr_en;

  assign wr_clr = we_i && (addr_i == ADDR_CLR);
  assign wr_en  = we_i && (addr_i == ADDR_EN);
  assign clr_o  = wr_clr ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (wr_en) begin
      for (int n = 0; n < NUM_CH; n++)
        en_q[EVT_PER_CH*n +: EVT_PER_CH] <= wdata_i[FLAGS_PER_CH*n+1 +: EVT_PER_CH];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_en_rd
    assign en_rd[FLAGS_PER_CH*n]                     = 1'b0;
    assign en_rd[FLAGS_PER_CH*n+1 +: EVT_PER_CH]     = en_q[EVT_PER_CH*n +: EVT_PER_CH];
  end

  always_comb begin
    case (addr_i)
      ADDR_STAT: rdata_o = flags_i;
      ADDR_EN:   rdata_o = en_rd;
      default:   rdata_o = '0;
    endcase
  end

  assign en_o = en_q;

  assert_clr_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CLR || addr_i == ADDR_RSV) |-> rdata_o == '0);
  assert_en_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(en_o));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              tc_evt_i,
  input  logic [NUM_CH-1:0]              ht_evt_i,
  input  logic [NUM_CH-1:0]              te_evt_i,
  input  logic                           reg_we_i,
  input  logic [1:0]                     reg_addr_i,
  input  logic [FLAGS_PER_CH*NUM_CH-1:0] reg_wdata_i,
  output logic [FLAGS_PER_CH*NUM_CH-1:0] reg_rdata_o,
  output logic [NUM_CH-1:0]              irq_o
);
  localparam int SW = FLAGS_PER_CH * NUM_CH;
  localparam int EW = EVT_PER_CH * NUM_CH;

  logic [SW-1:0] flags_all, clr_all;
  logic [EW-1:0] en_all;

  dma_irq_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flags_i (flags_all),
    .clr_o   (clr_all),
    .en_o    (en_all),
    .rdata_o (reg_rdata_o)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dma_irq_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   ({te_evt_i[n], ht_evt_i[n], tc_evt_i[n]}),
      .clr_i   (clr_all[FLAGS_PER_CH*n +: FLAGS_PER_CH]),
      .en_i    (en_all[EVT_PER_CH*n +: EVT_PER_CH]),
      .flags_o (flags_all[FLAGS_PER_CH*n +: FLAGS_PER_CH]),
      .irq_o   (irq_o[n])
    );
  end

  assert_stat_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_STAT && tc_evt_i == '0 && ht_evt_i == '0 && te_evt_i == '0)
    |=> $stable(flags_all));
  assert_irq_subset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o) || flags_all != '0);
endmodule

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;
  localparam int SW  = 4 * NCH;
  localparam int WD_CYCLES = 5000;

  typedef struct packed {
    logic [NCH-1:0] tc;
    logic [NCH-1:0] ht;
    logic [NCH-1:0] te;
    logic           we;
    logic [1:0]     addr;
    logic [SW-1:0]  wd;
    logic [SW-1:0]  st;
    logic [NCH-1:0] irq;
  } vec_t;

  localparam int NV = 13;
  // enables in force: ch0 all three, ch1 done only (enable word 0x2E)
  localparam vec_t VEC [NV] = '{
    '{7'h01, 7'h00, 7'h00, 1'b0, 2'd0, 28'h0,        28'h0000003, 7'h01}, // R2
    '{7'h00, 7'h02, 7'h00, 1'b0, 2'd0, 28'h0,        28'h0000053, 7'h01}, // R10 gated
    '{7'h00, 7'h00, 7'h40, 1'b0, 2'd0, 28'h0,        28'h9000053, 7'h01}, // R2 ch6
    '{7'h00, 7'h00, 7'h00, 1'b1, 2'd1, 28'h0000002,  28'h9000050, 7'h00}, // R4
    '{7'h00, 7'h00, 7'h00, 1'b1, 2'd1, 28'h0,        28'h9000050, 7'h00}, // R4 zeros
    '{7'h00, 7'h00, 7'h00, 1'b1, 2'd0, 28'hFFFFFFF,  28'h9000050, 7'h00}, // R7
    '{7'h02, 7'h00, 7'h00, 1'b1, 2'd1, 28'h0000020,  28'h9000070, 7'h02}, // R6
    '{7'h00, 7'h00, 7'h00, 1'b1, 2'd1, 28'h0000010,  28'h9000000, 7'h00}, // R5
    '{7'h00, 7'h00, 7'h40, 1'b1, 2'd1, 28'h1000000,  28'h9000000, 7'h00}, // R6 vs summary clear
    '{7'h00, 7'h00, 7'h00, 1'b1, 2'd1, 28'h8000000,  28'h0000000, 7'h00}, // R4
    '{7'h08, 7'h08, 7'h08, 1'b0, 2'd0, 28'h0,        28'h000F000, 7'h00}, // R3
    '{7'h00, 7'h00, 7'h00, 1'b1, 2'd1, 28'h0004000,  28'h000B000, 7'h00}, // R3
    '{7'h00, 7'h00, 7'h00, 1'b1, 2'd1, 28'h000A000,  28'h0000000, 7'h00}  // R3
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] tc_evt = '0, ht_evt = '0, te_evt = '0;
  logic           we = 1'b0;
  logic [1:0]     addr = 2'd0;
  logic [SW-1:0]  wdata = '0;
  logic [SW-1:0]  rdata;
  logic [NCH-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tc_evt_i(tc_evt), .ht_evt_i(ht_evt), .te_evt_i(te_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [NCH-1:0] t, input logic [NCH-1:0] h, input logic [NCH-1:0] e,
                       input logic w, input logic [1:0] a, input logic [SW-1:0] d);
    @(negedge clk);
    tc_evt = t; ht_evt = h; te_evt = e; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    tc_evt = '0; ht_evt = '0; te_evt = '0; we = 1'b0; wdata = '0; addr = 2'd0;
  endtask

  task automatic read(input logic [1:0] a, output logic [SW-1:0] v);
    addr = a;
    #1;
    v = rdata;
    addr = 2'd0;
    #1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    read(2'd0, v); check("R1 status", 32'(v), 32'h0);
    read(2'd2, v); check("R1 enable", 32'(v), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;

    apply('0, '0, '0, 1'b1, 2'd2, 28'h000002E);
    read(2'd2, v); check("R9 enable readback", 32'(v), 32'h2E);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].tc, VEC[i].ht, VEC[i].te, VEC[i].we, VEC[i].addr, VEC[i].wd);
      read(2'd0, v);
      check($sformatf("vec%0d status R2/R3/R4/R5/R6/R7", i), 32'(v), 32'(VEC[i].st));
      check($sformatf("vec%0d irq R10", i), 32'(irq), 32'(VEC[i].irq));
    end

    // R10: flag set with enable off, then enable it
    apply('0, 7'h04, '0, 1'b0, 2'd0, '0);
    read(2'd0, v); check("R10 flag independent of enable", 32'(v), 32'h0000500);
    check("R10 irq off while disabled", 32'(irq), 32'h0);
    apply('0, '0, '0, 1'b1, 2'd2, 28'h000042E);
    check("R10 irq on after enable", 32'(irq), 32'h04);
    read(2'd0, v); check("R10 enable leaves flags", 32'(v), 32'h0000500);

    // R11 hold over idle cycles
    repeat (5) @(posedge clk);
    #1;
    read(2'd0, v); check("R11 hold", 32'(v), 32'h0000500);

    // R8 clear and reserved addresses read zero
    read(2'd1, v); check("R8 clear reads zero", 32'(v), 32'h0);
    read(2'd3, v); check("R8 reserved reads zero", 32'(v), 32'h0);

    // R9 summary positions of enable word read zero
    apply('0, '0, '0, 1'b1, 2'd2, 28'hFFFFFFF);
    read(2'd2, v); check("R9 enable all", 32'(v), 32'h0EEEEEEE);
    check("R10 irq ch2 all enabled", 32'(irq), 32'h04);

    // R5 summary clear of all channels at once
    apply(7'h11, 7'h20, '0, 1'b0, 2'd0, '0);
    read(2'd0, v); check("R11 independent channels", 32'(v), 32'h0530503);
    apply('0, '0, '0, 1'b1, 2'd1, 28'h1111111);
    read(2'd0, v); check("R5 clear all summaries", 32'(v), 32'h0);
    check("R10 irq off after clear", 32'(irq), 32'h0);

    // R1 reset in mid-run
    apply(7'h7F, '0, '0, 1'b0, 2'd0, '0);
    rst_n = 1'b0;
    #1;
    read(2'd0, v); check("R1 async reset flags", 32'(v), 32'h0);
    read(2'd2, v); check("R1 async reset enables", 32'(v), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule